// File: doc/BRIEF.md
# Word-Addressed Multiply-Accumulate Peripheral

This block sits on a simple synchronous register bus and gives a processor a 16x16 multiplier with a 32-bit accumulator. Software picks one of four operations, unsigned multiply, signed multiply, unsigned accumulate or signed accumulate, by the address it writes the first operand to. A write of the second operand starts the operation, and the answer can be read one cycle later.

The 32-bit answer is read as a low word and a high word. A third word, the extension word, gives either a sign fill or a carry, depending on the selected operation. In an accumulate mode the result words show the running accumulator. In a multiply mode they show the last product. The register window starts at a parameterised base address. Bus accesses are 16 bits wide, and an odd byte address is treated as a byte access and does nothing.

Top module: `hw_mul_acc`

## Requirements
- R1: A write to byte offset 0x130, 0x132, 0x134 or 0x136 loads operand 1 and selects the mode: 0x130 selects unsigned multiply, 0x132 signed multiply, 0x134 unsigned accumulate and 0x136 signed accumulate. The mode is held until the next operand 1 write.
- R2: A write to offset 0x138 takes its data as operand 2 and performs the selected operation in that cycle. The new values can be read from the following cycle onwards, and this still holds when operand 2 writes come on consecutive cycles.
- R3: In the two signed modes both operands are treated as 16-bit two's-complement values. In the unsigned modes both are treated as zero-extended.
- R4: In a multiply mode the 32-bit product replaces the result, and the accumulator and the carry flag are cleared.
- R5: In an accumulate mode the product is added to the 32-bit accumulator, modulo 2^32, and the result is cleared. While an accumulate mode is selected, offsets 0x13A and 0x13C read the low and high accumulator halves. Otherwise they read the low and high result halves.
- R6: Offset 0x13E is the extension word. In unsigned multiply it reads 0x0000. In signed multiply it reads 0xFFFF if the result is negative, else 0x0000. In signed accumulate it reads 0xFFFF if the accumulator is negative, else 0x0000. In unsigned accumulate it reads 0x0001 if the most recent accumulate carried out of bit 31, else 0x0000.
- R7: Read data is 0x0000 when the read enable is low, for operand offsets (0x130 to 0x138), and for any address outside the window. Writes outside the window change nothing.
- R8: An access to an odd byte address is ignored. Such a write changes no state, and such a read returns 0x0000.
- R9: After reset, operand 1, the result, the accumulator and the carry are zero, and unsigned multiply is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | DATA_W (16) | Read data, combinational from registered state |

## Verification
The colliding pair is an accumulate and the accumulator update from the previous operand 2 write. With back-to-back writes, the adder takes in an accumulator that was registered on the edge just before. The bench provokes this with bursts of operand 2 writes on consecutive cycles, and with an operand 1 mode change followed at once by operand 2. It then compares both result words and the carry or sign word against a running arithmetic model of the accumulator and the 33-bit sum.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Operation mode; the encoding equals the operand-1 word slot that selects it.
  typedef enum logic [1:0] {
    MODE_UMUL = 2'd0,
    MODE_SMUL = 2'd1,
    MODE_UMAC = 2'd2,
    MODE_SMAC = 2'd3
  } mac_mode_e;

  localparam int unsigned SLOT_W    = 3;
  localparam int unsigned WIN_WORDS = 1 << SLOT_W;

  // Word slots inside the window (byte offset = base + 2*slot).
  localparam logic [SLOT_W-1:0] SLOT_OP2 = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_LO  = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_HI  = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_EXT = 3'd7;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 'h130
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              re,
  output logic              op1_we,
  output mac_mode_e         op1_mode,
  output logic              op2_we,
  output logic              rd_hit,
  output logic [SLOT_W-1:0] rd_slot
);

  localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(BASE);
  localparam int unsigned       WIN_BYTES = 2 * WIN_WORDS;

  logic [ADDR_W-1:0] rel;
  logic              in_win;
  logic [SLOT_W-1:0] slot;

  always_comb begin
    rel    = addr - BASE_A;
    in_win = (addr >= BASE_A) && (rel < ADDR_W'(WIN_BYTES)) && !addr[0];
    slot   = rel[SLOT_W:1];
  end

  always_comb begin
    op1_we   = we && in_win && !slot[SLOT_W-1];
    op1_mode = mac_mode_e'(slot[1:0]);
    op2_we   = we && in_win && (slot == SLOT_OP2);
    rd_hit   = re && in_win;
    rd_slot  = slot;
  end

  // Byte (odd) addresses never reach the register file.
  always_comb begin
    if (addr[0] === 1'b1) begin
      assert_odd_blocked_R8: assert (!op1_we && !op2_we && !rd_hit);
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op1_we,
  input  mac_mode_e         op1_mode,
  input  logic              op2_we,
  input  logic [DATA_W-1:0] wdata,
  output mac_mode_e         mode_q,
  output logic [ACC_W-1:0]  res_q,
  output logic [ACC_W-1:0]  acc_q,
  output logic              carry_q
);

  localparam int unsigned EXT_W = ACC_W - DATA_W;

  logic [DATA_W-1:0] op1_q, op1_d;
  mac_mode_e         mode_d;
  logic [ACC_W-1:0]  res_d, acc_d;
  logic              carry_d;
  logic              signed_op, accum_op;
  logic [ACC_W-1:0]  a_w, b_w, prod;
  logic [ACC_W:0]    sum;

  always_comb begin
    signed_op = (mode_q == MODE_SMUL) || (mode_q == MODE_SMAC);
    accum_op  = (mode_q == MODE_UMAC) || (mode_q == MODE_SMAC);
    a_w  = {{EXT_W{signed_op & op1_q[DATA_W-1]}}, op1_q};
    b_w  = {{EXT_W{signed_op & wdata[DATA_W-1]}}, wdata};
    prod = a_w * b_w;
    sum  = {1'b0, acc_q} + {1'b0, prod};
  end

  // Next-state logic
  always_comb begin
    op1_d   = op1_q;
    mode_d  = mode_q;
    res_d   = res_q;
    acc_d   = acc_q;
    carry_d = carry_q;
    if (op1_we) begin
      op1_d  = wdata;
      mode_d = op1_mode;
    end
    if (op2_we) begin
      if (accum_op) begin
        acc_d   = sum[ACC_W-1:0];
        carry_d = sum[ACC_W];
        res_d   = '0;
      end else begin
        res_d   = prod;
        acc_d   = '0;
        carry_d = 1'b0;
      end
    end
  end

  // Operand / mode register, enabled by operand-1 writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1_q  <= '0;
      mode_q <= MODE_UMUL;
    end else if (op1_we) begin
      op1_q  <= op1_d;
      mode_q <= mode_d;
    end
  end

  // Result / accumulator register, enabled by operand-2 writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (op2_we) begin
      res_q   <= res_d;
      acc_q   <= acc_d;
      carry_q <= carry_d;
    end
  end

  assert_mul_clears_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_we && !accum_op) |=> (acc_q == '0) && !carry_q);

  assert_mac_clears_res_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_we && accum_op) |=> (res_q == '0));

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op1_we |=> $stable(mode_q));

  assert_op2_only_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op2_we |=> $stable(acc_q) && $stable(res_q) && $stable(carry_q));

endmodule

// File: rtl/mac_readmux.sv
module mac_readmux
  import mac_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 2 * DATA_W
) (
  input  logic              rd_hit,
  input  logic [SLOT_W-1:0] rd_slot,
  input  mac_mode_e         mode_q,
  input  logic [ACC_W-1:0]  res_q,
  input  logic [ACC_W-1:0]  acc_q,
  input  logic              carry_q,
  output logic [DATA_W-1:0] rdata
);

  logic [ACC_W-1:0]  view;
  logic [DATA_W-1:0] ext;

  always_comb begin
    view = ((mode_q == MODE_UMAC) || (mode_q == MODE_SMAC)) ? acc_q : res_q;
    unique case (mode_q)
      MODE_UMUL: ext = '0;
      MODE_SMUL: ext = {DATA_W{res_q[ACC_W-1]}};
      MODE_UMAC: ext = DATA_W'(carry_q);
      MODE_SMAC: ext = {DATA_W{acc_q[ACC_W-1]}};
      default:   ext = '0;
    endcase
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (rd_slot)
        SLOT_LO:  rdata = view[DATA_W-1:0];
        SLOT_HI:  rdata = view[ACC_W-1:DATA_W];
        SLOT_EXT: rdata = ext;
        default:  rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/hw_mul_acc.sv
module hw_mul_acc
  import mac_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BASE   = 'h130
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned ACC_W = 2 * DATA_W;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              op1_we, op2_we, rd_hit;
  mac_mode_e         op1_mode, mode_q;
  logic [SLOT_W-1:0] rd_slot;
  logic [ACC_W-1:0]  res_q, acc_q;
  logic              carry_q;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  mac_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_decode (
    .addr     (bus_addr),
    .we       (bus_we),
    .re       (bus_re),
    .op1_we   (op1_we),
    .op1_mode (op1_mode),
    .op2_we   (op2_we),
    .rd_hit   (rd_hit),
    .rd_slot  (rd_slot)
  );

  mac_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_datapath (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .op1_we   (op1_we),
    .op1_mode (op1_mode),
    .op2_we   (op2_we),
    .wdata    (bus_wdata),
    .mode_q   (mode_q),
    .res_q    (res_q),
    .acc_q    (acc_q),
    .carry_q  (carry_q)
  );

  mac_readmux #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_readmux (
    .rd_hit  (rd_hit),
    .rd_slot (rd_slot),
    .mode_q  (mode_q),
    .res_q   (res_q),
    .acc_q   (acc_q),
    .carry_q (carry_q),
    .rdata   (bus_rdata)
  );

  assert_ext_code_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_hit && rd_slot == SLOT_EXT) |->
      (bus_rdata == '0 || bus_rdata == DATA_W'(1) || bus_rdata == '1));

  assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_hit |-> (bus_rdata == '0));

endmodule

// File: tb/tb_hw_mul_acc.sv
module tb_hw_mul_acc;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_we, bus_re;
  logic [15:0] bus_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench model state
  int unsigned m_mode;
  logic [15:0] m_op1;
  logic [31:0] m_res, m_acc;
  logic        m_carry;

  hw_mul_acc dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [11:0] a);
    logic [31:0] v;
    v = (m_mode >= 2) ? m_acc : m_res;
    case (a)
      12'h13A: return v[15:0];
      12'h13C: return v[31:16];
      12'h13E: case (m_mode)
                 0: return 16'h0000;
                 1: return {16{m_res[31]}};
                 2: return {15'b0, m_carry};
                 default: return {16{m_acc[31]}};
               endcase
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [15:0] d);
    longint ai, bi, p;
    logic [32:0] s;
    if (a >= 12'h130 && a <= 12'h136 && !a[0]) begin
      m_op1  = d;
      m_mode = (a - 12'h130) / 2;
    end else if (a == 12'h138) begin
      if (m_mode == 1 || m_mode == 3) begin
        ai = longint'($signed(m_op1));
        bi = longint'($signed(d));
      end else begin
        ai = longint'({48'b0, m_op1});
        bi = longint'({48'b0, d});
      end
      p = ai * bi;
      if (m_mode >= 2) begin
        s = {1'b0, m_acc} + {1'b0, p[31:0]};
        m_acc = s[31:0]; m_carry = s[32]; m_res = '0;
      end else begin
        m_res = p[31:0]; m_acc = '0; m_carry = 1'b0;
      end
    end
  endtask

  // Writes issued by consecutive calls land on consecutive cycles.
  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, input logic en, output logic [15:0] q);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0; bus_re = en;
    #1 q = bus_rdata;
  endtask

  task automatic check_outs(input string req);
    logic [15:0] q;
    rd(12'h13A, 1'b1, q); chk({req, " lo"}, q, exp_rd(12'h13A));
    rd(12'h13C, 1'b1, q); chk({req, " hi"}, q, exp_rd(12'h13C));
    rd(12'h13E, 1'b1, q); chk("R6 ext", q, exp_rd(12'h13E));
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q;
    logic [15:0] vals [8];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
             16'h8000, 16'h8001, 16'hFFFF, 16'h1234};
    m_mode = 0; m_op1 = '0; m_res = '0; m_acc = '0; m_carry = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    check_outs("R9");
    wr(12'h138, 16'h0005);               // op1 is zero, unsigned multiply
    check_outs("R9 R2");

    // R8: odd addresses are ignored
    wr(12'h130, 16'h0005);
    wr(12'h133, 16'hFFFF);               // odd: must not load or change mode
    wr(12'h139, 16'h0009);               // odd: must not trigger
    rd(12'h13A, 1'b1, q); chk("R8 no trigger", q, 16'h0000);
    wr(12'h138, 16'h0003);
    check_outs("R8");                    // 5*3 = 15 unsigned
    rd(12'h13B, 1'b1, q); chk("R8 odd read", q, 16'h0000);

    // R7: quiet reads and out-of-window writes
    rd(12'h13A, 1'b0, q); chk("R7 re low", q, 16'h0000);
    rd(12'h130, 1'b1, q); chk("R7 op1 slot", q, 16'h0000);
    rd(12'h138, 1'b1, q); chk("R7 op2 slot", q, 16'h0000);
    rd(12'h140, 1'b1, q); chk("R7 outside", q, 16'h0000);
    rd(12'h12E, 1'b1, q); chk("R7 below", q, 16'h0000);
    wr(12'h140, 16'hABCD);
    wr(12'h12E, 16'h1111);
    check_outs("R7 unchanged");

    // R1 R3 R4 R5 R6: sweep of every mode over corner operand pairs
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          wr(12'h130 + 12'(2*m), vals[i]);
          wr(12'h138, vals[j]);
          check_outs((m < 2) ? "R1 R3 R4" : "R1 R3 R5");
        end
      end
    end

    // R2: back-to-back operand 2 writes accumulate each time (carry R6)
    wr(12'h134, 16'hFFFF);
    wr(12'h138, 16'hFFFF);
    wr(12'h138, 16'hFFFF);
    wr(12'h138, 16'hFFFF);
    check_outs("R2 burst umac");
    wr(12'h136, 16'h8000);
    wr(12'h138, 16'h7FFF);
    wr(12'h138, 16'h7FFF);
    check_outs("R2 burst smac");

    // R5: switching mode shows the other view; R4 then clears accumulator
    wr(12'h132, 16'hFFFE);
    check_outs("R5 view switch");
    wr(12'h138, 16'h0003);
    check_outs("R4 smul");
    wr(12'h134, 16'h0002);
    check_outs("R4 acc cleared");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule